// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block is a master controller for an external bus where address and data share one set of sixteen pins. An internal client hands it one access at a time: an address, write data, a read/write flag and a device-width flag. The block then sequences the shared pins, the address-latch strobe and the active-low read and write strobes so that an external latch can capture the address and an SRAM or peripheral can complete the transfer.

Two device widths are supported. With a 16-bit device, the address is sixteen bits and is presented in one latch phase. With an 8-bit device, the address is twenty-four bits and is presented in two latch phases: the top byte first, then the low sixteen bits. In both modes the data strobe stays active for a fixed window of three core cycles, so one transfer never takes fewer than three cycles. Reads return their data on a one-cycle response pulse. Writes complete without a response.

Top module: `mux_bus_master`

## Requirements
- R1: During reset and in the first idle cycle after it, ale=0, rd_n=1, wr_n=1, ad_oe=0, req_ready=1 and rsp_valid=0.
- R2: In 16-bit mode (req_wide=1), the cycle after a request is accepted has ale=1 and ad_oe=1, with ad_out equal to addr[15:0]. It is followed by exactly one hold cycle with ale=0 and both strobes high.
- R3: In 8-bit mode (req_wide=0), the cycle after acceptance has ale=1 with ad_out={addr[23:16],8'h00}. Next comes one cycle with ale=0 and the same value on ad_out. Then one cycle with ale=1 and ad_out=addr[15:0], then one hold cycle with ale=0.
- R4: rd_n and wr_n are never low in the same cycle. In the cycle right after any cycle with ale=1, both strobes are high.
- R5: A read holds rd_n low for exactly 3 consecutive cycles, and ad_oe is 0 in every one of those cycles.
- R6: Read data is taken from ad_in at the clock edge where rd_n returns high. rsp_valid is 1 for exactly the following cycle. rsp_rdata is ad_in in 16-bit mode, and {8'h00, ad_in[7:0]} in 8-bit mode.
- R7: A write holds wr_n low for exactly 3 consecutive cycles. From the hold cycle through the last wr_n-low cycle, ad_oe=1 and ad_out carries the data: wdata in 16-bit mode, {8'h00, wdata[7:0]} in 8-bit mode.
- R8: req_ready is 0 from the cycle after acceptance until the last strobe cycle. A request presented while req_ready is 0 is ignored: no new ale pulse follows the end of the access.
- R9: A write produces no rsp_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client offers an access |
| req_ready | output | 1 | Block is idle and accepts an access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| req_addr | input | 24 | Access address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid for one cycle |
| rsp_rdata | output | 16 | Read data |
| ad_out | output | 16 | Value driven on the shared address/data pins |
| ad_in | input | 16 | Value sampled from the shared pins |
| ad_oe | output | 1 | Output enable for the shared pins |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bench compares every pin cycle by cycle against a phase list it builds itself, for reads and writes in both widths. It chooses 8-bit addresses whose top byte and low half differ, so that a design which presents the halves in the wrong order, or skips the gap between the two latch pulses, shows a wrong value on the pins. The 8-bit read drives different values on both lanes of ad_in, which catches a design that returns the upper lane instead of zero. A request poked in during a busy access exposes a design that queues it and starts an extra ale pulse. Counting strobe-low cycles catches an off-by-one in the data window, and the write tests catch a spurious response pulse.

// File: rtl/mbp_pkg.sv
package mbp_pkg;

  localparam int AD_W   = 16;
  localparam int ADDR_W = 24;
  localparam int BYTE_W = 8;
  localparam int HI_W   = ADDR_W - AD_W;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ALE_HI = 3'd1,
    PH_GAP    = 3'd2,
    PH_ALE_LO = 3'd3,
    PH_HOLD   = 3'd4,
    PH_DATA   = 3'd5
  } phase_e;

  // Upper address bits placed on the top lanes for the first latch phase.
  function automatic logic [AD_W-1:0] hi_addr_word(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:AD_W], {(AD_W-HI_W){1'b0}}};
  endfunction

  // Lower address bits for the second (or only) latch phase.
  function automatic logic [AD_W-1:0] lo_addr_word(input logic [ADDR_W-1:0] a);
    return a[AD_W-1:0];
  endfunction

  // Narrow devices use the low byte lane only.
  function automatic logic [AD_W-1:0] lane_fit(input logic [AD_W-1:0] d, input logic wide);
    return wide ? d : {{(AD_W-BYTE_W){1'b0}}, d[BYTE_W-1:0]};
  endfunction

endpackage

// File: rtl/mbp_seq.sv
module mbp_seq
  import mbp_pkg::*;
#(
  parameter int DATA_CYCLES = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   start_wide,
  output phase_e phase,
  output logic   data_last
);

  localparam int CW = $clog2(DATA_CYCLES + 1);

  logic [CW-1:0] cnt;

  assign data_last = (phase == PH_DATA) && (cnt == CW'(DATA_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) phase <= start_wide ? PH_ALE_LO : PH_ALE_HI;
          cnt <= '0;
        end
        PH_ALE_HI: phase <= PH_GAP;
        PH_GAP:    phase <= PH_ALE_LO;
        PH_ALE_LO: phase <= PH_HOLD;
        PH_HOLD: begin
          phase <= PH_DATA;
          cnt   <= '0;
        end
        PH_DATA: begin
          if (data_last) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/mbp_pin_drive.sv
module mbp_pin_drive
  import mbp_pkg::*;
(
  input  phase_e            phase,
  input  logic              is_write,
  input  logic              is_wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [AD_W-1:0]   wdata,
  output logic [AD_W-1:0]   ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n
);

  logic [AD_W-1:0] data_word;
  assign data_word = lane_fit(wdata, is_wide);

  always_comb begin
    ad_out = '0;
    ad_oe  = 1'b0;
    ale    = 1'b0;
    rd_n   = 1'b1;
    wr_n   = 1'b1;
    case (phase)
      PH_ALE_HI: begin
        ale    = 1'b1;
        ad_oe  = 1'b1;
        ad_out = hi_addr_word(addr);
      end
      PH_GAP: begin
        ad_oe  = 1'b1;
        ad_out = hi_addr_word(addr);
      end
      PH_ALE_LO: begin
        ale    = 1'b1;
        ad_oe  = 1'b1;
        ad_out = lo_addr_word(addr);
      end
      PH_HOLD: begin
        ad_oe  = 1'b1;
        ad_out = is_write ? data_word : lo_addr_word(addr);
      end
      PH_DATA: begin
        if (is_write) begin
          ad_oe  = 1'b1;
          ad_out = data_word;
          wr_n   = 1'b0;
        end else begin
          rd_n   = 1'b0;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mbp_rd_capture.sv
module mbp_rd_capture
  import mbp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic            is_wide,
  input  logic [AD_W-1:0] ad_in,
  output logic            rsp_valid,
  output logic [AD_W-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= lane_fit(ad_in, is_wide);
    end
  end

endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
  import mbp_pkg::*;
#(
  parameter int DATA_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [AD_W-1:0]   req_wdata,
  output logic              rsp_valid,
  output logic [AD_W-1:0]   rsp_rdata,
  output logic [AD_W-1:0]   ad_out,
  input  logic [AD_W-1:0]   ad_in,
  output logic              ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n
);

  phase_e            phase;
  logic              data_last;
  logic              req_fire;
  logic              rd_capture;
  logic              cur_write;
  logic              cur_wide;
  logic [ADDR_W-1:0] cur_addr;
  logic [AD_W-1:0]   cur_wdata;

  assign req_ready  = (phase == PH_IDLE);
  assign req_fire   = req_valid && req_ready;
  assign rd_capture = data_last && !cur_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_write <= 1'b0;
      cur_wide  <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else if (req_fire) begin
      cur_write <= req_write;
      cur_wide  <= req_wide;
      cur_addr  <= req_addr;
      cur_wdata <= req_wdata;
    end
  end

  mbp_seq #(.DATA_CYCLES(DATA_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (req_fire),
    .start_wide (req_wide),
    .phase      (phase),
    .data_last  (data_last)
  );

  mbp_pin_drive u_pins (
    .phase    (phase),
    .is_write (cur_write),
    .is_wide  (cur_wide),
    .addr     (cur_addr),
    .wdata    (cur_wdata),
    .ad_out   (ad_out),
    .ad_oe    (ad_oe),
    .ale      (ale),
    .rd_n     (rd_n),
    .wr_n     (wr_n)
  );

  mbp_rd_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (rd_capture),
    .is_wide   (cur_wide),
    .ad_in     (ad_in),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/mbp_checker.sv
module mbp_checker
  import mbp_pkg::*;
#(
  parameter int DATA_CYCLES = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic [AD_W-1:0] ad_out,
  input logic            ad_oe,
  input logic            ale,
  input logic            rd_n,
  input logic            wr_n
);

  logic [7:0] low_run;
  logic       strobe_low;
  assign strobe_low = !rd_n || !wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else if (strobe_low) low_run <= low_run + 1'b1;
    else low_run <= '0;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n)); // R4
  AST_ALE_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) ale |=> (rd_n && wr_n)); // R4
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !ad_oe); // R5
  AST_STROBE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) strobe_low |-> (low_run < 8'(DATA_CYCLES))); // R5
  AST_READ_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rd_n) |-> rsp_valid); // R6
  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n) !wr_n |-> ad_oe); // R7
  AST_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!wr_n && $past(!wr_n)) |-> $stable(ad_out)); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) (ale || strobe_low) |-> !req_ready); // R8
  AST_WRITE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n) $rose(wr_n) |-> !rsp_valid); // R9

endmodule

bind mux_bus_master mbp_checker #(.DATA_CYCLES(DATA_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .ad_out    (ad_out),
  .ad_oe     (ad_oe),
  .ale       (ale),
  .rd_n      (rd_n),
  .wr_n      (wr_n)
);

// File: tb/mux_bus_master_test.sv
module mux_bus_master_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_wide = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] ad_out;
  logic [15:0] ad_in = '0;
  logic        ad_oe;
  logic        ale;
  logic        rd_n;
  logic        wr_n;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_master uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Pin bundle {ale, rd_n, wr_n, ad_oe, ad_out}
  function automatic logic [19:0] pins();
    return {ale, rd_n, wr_n, ad_oe, ad_out};
  endfunction

  task automatic test_reset();
    check(pins() == {4'b0110, 16'h0000} && req_ready && !rsp_valid, "R1",
          "reset pins/ready/rsp", {11'd0, req_ready, rsp_valid, pins()}, {13'h800, 4'b0110, 16'h0});
    @(negedge clk);
    check(pins() == {4'b0110, 16'h0000} && req_ready && !rsp_valid, "R1",
          "first idle cycle", {11'd0, req_ready, rsp_valid, pins()}, {13'h800, 4'b0110, 16'h0});
  endtask

  task automatic do_access(input bit wr, input bit wide, input logic [23:0] addr,
                           input logic [15:0] wd, input logic [15:0] din,
                           input bit poke, input string name);
    int n;
    logic [15:0] hi, lo, wfit, rfit;
    n    = wide ? 5 : 7;
    hi   = {addr[23:16], 8'h00};
    lo   = addr[15:0];
    wfit = wide ? wd : {8'h00, wd[7:0]};
    rfit = wide ? din : {8'h00, din[7:0]};
    @(negedge clk);
    req_write = wr; req_wide = wide; req_addr = addr; req_wdata = wd;
    req_valid = 1'b1; ad_in = din;
    check(req_ready == 1'b1, "R8", {name, " ready before accept"}, {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      int idx;
      logic [3:0] ectl;
      logic [15:0] ead;
      string rq;
      idx = wide ? k + 2 : k;
      case (idx)
        0: begin ectl = 4'b1111; ead = hi; rq = "R3"; end
        1: begin ectl = 4'b0111; ead = hi; rq = "R3"; end
        2: begin ectl = 4'b1111; ead = lo; rq = wide ? "R2" : "R3"; end
        3: begin ectl = 4'b0111; ead = wr ? wfit : lo; rq = wr ? "R7" : (wide ? "R2" : "R3"); end
        default: begin
          ectl = wr ? 4'b0101 : 4'b0010;
          ead  = wr ? wfit : 16'h0000;
          rq   = wr ? "R7" : "R5";
        end
      endcase
      if (ectl[0])
        check(pins() == {ectl, ead}, rq, $sformatf("%s cycle %0d pins", name, k),
              {12'd0, pins()}, {12'd0, ectl, ead});
      else
        check(pins()[19:16] == ectl, rq, $sformatf("%s cycle %0d ctl", name, k),
              {28'd0, pins()[19:16]}, {28'd0, ectl});
      check(!rd_n -> rd_n || wr_n, "R4", $sformatf("%s cycle %0d strobes", name, k),
            {30'd0, rd_n, wr_n}, 32'd1);
      check(req_ready == 1'b0, "R8", $sformatf("%s cycle %0d busy", name, k),
            {31'd0, req_ready}, 32'd0);
      if (poke && k == 1) begin req_valid = 1'b1; req_addr = 24'hFFFFFF; end
      if (poke && k == 2) req_valid = 1'b0;
      @(negedge clk);
    end
    check(req_ready == 1'b1, "R8", {name, " ready after access"}, {31'd0, req_ready}, 32'd1);
    if (wr)
      check(rsp_valid == 1'b0, "R9", {name, " no response for write"}, {31'd0, rsp_valid}, 32'd0);
    else
      check(rsp_valid == 1'b1 && rsp_rdata == rfit, "R6", {name, " read response"},
            {15'd0, rsp_valid, rsp_rdata}, {15'd0, 1'b1, rfit});
    @(negedge clk);
    check(rsp_valid == 1'b0, wr ? "R9" : "R6", {name, " response one cycle"}, {31'd0, rsp_valid}, 32'd0);
    if (poke) begin
      for (int j = 0; j < 3; j++) begin
        check(!ale && rd_n && wr_n, "R8", $sformatf("%s no queued access %0d", name, j),
              {29'd0, ale, rd_n, wr_n}, 32'b011);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();                     // R1 (checked during reset, then released)
    rst_n = 1'b1;
    @(negedge clk);
    check(pins() == {4'b0110, 16'h0000} && req_ready, "R1", "idle after release",
          {12'd0, pins()}, {12'd0, 4'b0110, 16'h0});
    do_access(1'b0, 1'b1, 24'h005A3C, 16'h0000, 16'hBEEF, 1'b0, "read16");   // R2 R5 R6
    do_access(1'b1, 1'b1, 24'h001234, 16'hC0DE, 16'h0000, 1'b0, "write16");  // R2 R7 R9
    do_access(1'b0, 1'b0, 24'hA50F0F, 16'h0000, 16'h7E81, 1'b0, "read8");    // R3 R6
    do_access(1'b1, 1'b0, 24'h3CFFEE, 16'hAB96, 16'h0000, 1'b0, "write8");   // R3 R7
    do_access(1'b0, 1'b1, 24'h00F00D, 16'h0000, 16'h1357, 1'b1, "busy-poke"); // R8
    do_access(1'b1, 1'b0, 24'hFF0001, 16'h5AA5, 16'h0000, 1'b1, "busy-poke8"); // R4 R8
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule